// File: doc/BRIEF.md
# SPI Controller with Fault Flags

This block is a single-character SPI engine that can act as bus master or as a selected slave. Software works it through two register strobes: a write to the 8-bit control/status register and a write to the data buffer. It reads back the control/status byte and the last received character. A received-character read strobe marks the buffer as consumed. The engine transfers 8-bit characters, MSB first, in clock mode 0: SCLK idles low, data is sampled on the rising edge and shifted on the falling edge. In master mode the SCLK half period is `HALF_DIV` system clocks. In slave mode SCLK, MOSI and the active-low select pass through a two-flop synchronizer before their edges are detected.

Four sticky flags report events: mode fault, write collision, receive overrun and transfer complete. The interrupt output is their OR, qualified by a global interrupt-enable input. The sequencing is a four-state machine:
- `ST_IDLE` goes to `ST_M_XFER` on a master start, or to `ST_S_SEL` when the engine is enabled as a slave and the select is asserted.
- `ST_M_XFER` returns to `ST_IDLE` on its last falling SCLK edge. It also returns early on a disable, on a mode fault, or when the master bit is cleared.
- `ST_S_SEL` goes to `ST_S_XFER` on the first synchronized SCLK rise. It returns to `ST_IDLE` on a deselect, on a disable, or when master mode is set.
- `ST_S_XFER` goes back to `ST_S_SEL` on the eighth rise. It drops to `ST_IDLE` on a deselect or a disable.

Top module: `spi_fault_ctl`

## Requirements
- R1: After reset the control/status byte reads 00h, irq is low, SCLK is low, and none of the SCLK, MOSI or MISO output enables is set.
- R2: Control/status bit positions: bit 0 enable, bit 1 master, bit 2 fault-detect enable, bit 3 mode fault, bit 4 write collision, bit 5 overrun, bit 6 complete, bit 7 busy. Bits 0 to 6 are written directly. A write to bit 7 is ignored, and busy reads 1 exactly while a transfer is in progress.
- R3: With enable at 0, a data write starts no transfer, SCLK stays low and the baud counter does not run. Clearing enable during a transfer aborts it without setting the complete flag.
- R4: In master mode with enable set and busy clear, a data write starts a transfer, and busy reads 1 from the next cycle. Busy stays high for exactly 16·HALF_DIV cycles, then the complete flag is set. The bits shifted out on MOSI equal the written byte, and the buffer receives the 8 bits sampled from MISO.
- R5: The master bit can go from 0 to 1 only while the synchronized select is deasserted. Otherwise that bit of the write is dropped.
- R6: With master and fault-detect enable set, a high-to-low change of the select sets the mode-fault flag. With fault-detect enable clear, the select has no effect in master mode.
- R7: A mode fault during a master transfer aborts it. Busy clears, the master bit clears, and the SCLK and MOSI enables drop.
- R8: A data write while busy sets the write-collision flag and leaves the ongoing transfer and its data unchanged.
- R9: If a character completes while the previous one is unread, the overrun flag is set and the buffer keeps the older character.
- R10: Flags 3 to 6 stay set until software writes 0 to them. Software writing 1 sets them just as hardware does.
- R11: irq is high exactly when irq_en is high and at least one of bits 3 to 6 is set.
- R12: In slave mode the MISO enable is high only while selected. MOSI is sampled on synchronized SCLK rises, MISO shifts the loaded byte MSB first on falls, and the eighth rise stores the character and sets the complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the control/status register |
| data_we | input | 1 | Write strobe for the data buffer |
| buf_re | input | 1 | Read strobe marking the received character consumed |
| wdata | input | 8 | Write data for either register |
| ctl_rdata | output | 8 | Control/status byte |
| buf_rdata | output | 8 | Last stored received character |
| irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | SCLK from the bus (slave mode) |
| sclk_o | output | 1 | SCLK driven in master mode |
| sclk_oe | output | 1 | SCLK output enable |
| mosi_i | input | 1 | MOSI from the bus (slave mode) |
| mosi_o | output | 1 | MOSI driven in master mode |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the bus (master mode) |
| miso_o | output | 1 | MISO driven in slave mode |
| miso_oe | output | 1 | MISO output enable |
| ssel_n_i | input | 1 | Active-low slave select |

## Verification
Master transfers run with random pairs of transmit and remote bytes. Asymmetric values show any bit-order or sampling-edge error, because both directions are compared at once. A busy count of exactly 16·HALF_DIV checks the baud divisor. Directed patterns probe one cause at a time: a write during busy, which must not disturb the shifted byte, and two completions without a read, which must keep the first byte. A select edge is sent once with fault detection off and once with it on in mid-transfer, which tells an ignored select apart from an abort. A bit-banged slave exchange with a random MOSI byte checks the synchronized sampling and the MISO shift order.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = $clog2(CHAR_W);

    localparam int B_EN   = 0;
    localparam int B_MST  = 1;
    localparam int B_FDE  = 2;
    localparam int B_MODF = 3;
    localparam int B_WCOL = 4;
    localparam int B_ROVR = 5;
    localparam int B_TC   = 6;
    localparam int B_BUSY = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_M_XFER,
        ST_S_SEL,
        ST_S_XFER
    } spi_state_e;
endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            q      <= INIT;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // counter is held at zero while stopped, so no tick follows an idle cycle
    p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> !tick);
endmodule

// File: rtl/spi_fault_ctl.sv
module spi_fault_ctl
    import spi_fault_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              data_we,
    input  logic              buf_re,
    input  logic [CHAR_W-1:0] wdata,
    output logic [CHAR_W-1:0] ctl_rdata,
    output logic [CHAR_W-1:0] buf_rdata,
    input  logic              irq_en,
    output logic              irq,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ssel_n_i
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

    spi_state_e        state, state_n;
    logic [CHAR_W-2:0] ctl_q;
    logic [CHAR_W-1:0] tx_q, rx_q, rxbuf_q, rx_full;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              sclk_q, unread_q;
    logic              ssel_n_d, sclk_d;
    logic [2:0]        s_q;
    logic              s_ssel_n, s_sclk, s_mosi;
    logic              tick, run;

    spi_sync2 #(.W(3), .INIT(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ssel_n_i, sclk_i, mosi_i}),
        .q    (s_q)
    );
    assign s_ssel_n = s_q[2];
    assign s_sclk   = s_q[1];
    assign s_mosi   = s_q[0];

    spi_baud_gen #(.HALF_DIV(HALF_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    // decoded conditions
    logic en, mstm, fde, busy, ssel_act, ssel_fall, sclk_rise, sclk_fall;
    logic start_m, modf_evt, m_rise, m_fall, m_last, s_last, done;

    assign en        = ctl_q[B_EN];
    assign mstm      = ctl_q[B_MST];
    assign fde       = ctl_q[B_FDE];
    assign busy      = (state == ST_M_XFER) || (state == ST_S_XFER);
    assign ssel_act  = !s_ssel_n;
    assign ssel_fall = ssel_n_d && !s_ssel_n;
    assign sclk_rise = !sclk_d && s_sclk;
    assign sclk_fall = sclk_d && !s_sclk;
    assign start_m   = data_we && en && mstm && !busy;
    assign modf_evt  = mstm && fde && ssel_fall;
    assign run       = en && (state == ST_M_XFER);
    assign m_rise    = (state == ST_M_XFER) && tick && !sclk_q;
    assign m_fall    = (state == ST_M_XFER) && tick && sclk_q;
    assign m_last    = m_fall && (bitcnt_q == LAST_BIT);
    assign s_last    = (state == ST_S_XFER) && sclk_rise && (bitcnt_q == LAST_BIT);
    assign done      = m_last || s_last;
    assign rx_full   = m_last ? rx_q : {rx_q[CHAR_W-2:0], s_mosi};

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (en && start_m)                  state_n = ST_M_XFER;
                else if (en && !mstm && ssel_act)   state_n = ST_S_SEL;
            end
            ST_M_XFER: begin
                if (!en || !mstm || modf_evt || m_last) state_n = ST_IDLE;
            end
            ST_S_SEL: begin
                if (!en || mstm || !ssel_act)       state_n = ST_IDLE;
                else if (sclk_rise)                 state_n = ST_S_XFER;
            end
            ST_S_XFER: begin
                if (!en || !ssel_act)               state_n = ST_IDLE;
                else if (s_last)                    state_n = ST_S_SEL;
            end
            default:                                state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            rxbuf_q  <= '0;
            bitcnt_q <= '0;
            sclk_q   <= 1'b0;
            unread_q <= 1'b0;
            ssel_n_d <= 1'b1;
            sclk_d   <= 1'b0;
        end else begin
            ssel_n_d <= s_ssel_n;
            sclk_d   <= s_sclk;

            if (ctl_we) begin
                ctl_q[B_EN]      <= wdata[B_EN];
                ctl_q[B_MST]     <= wdata[B_MST] && (mstm || !ssel_act);
                ctl_q[B_TC:B_FDE] <= wdata[B_TC:B_FDE];
            end
            if (modf_evt) begin
                ctl_q[B_MODF] <= 1'b1;
                if (state == ST_M_XFER) ctl_q[B_MST] <= 1'b0;
            end
            if (data_we && busy) ctl_q[B_WCOL] <= 1'b1;
            if (done) begin
                ctl_q[B_TC] <= 1'b1;
                if (unread_q) ctl_q[B_ROVR] <= 1'b1;
            end

            if (data_we && !busy)
                tx_q <= wdata;
            else if (m_fall || ((state == ST_S_XFER) && sclk_fall))
                tx_q <= {tx_q[CHAR_W-2:0], 1'b0};

            if (m_rise)
                rx_q <= {rx_q[CHAR_W-2:0], miso_i};
            else if (((state == ST_S_SEL) || (state == ST_S_XFER)) && sclk_rise)
                rx_q <= rx_full;

            if ((state == ST_IDLE) || (state_n == ST_IDLE) || done)
                bitcnt_q <= '0;
            else if (m_fall || (((state == ST_S_SEL) || (state == ST_S_XFER)) && sclk_rise))
                bitcnt_q <= bitcnt_q + 1'b1;

            if ((state == ST_M_XFER) && (state_n == ST_M_XFER))
                sclk_q <= tick ? !sclk_q : sclk_q;
            else
                sclk_q <= 1'b0;

            if (buf_re) unread_q <= 1'b0;
            if (done && !unread_q) begin
                rxbuf_q  <= rx_full;
                unread_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ctl_rdata = {busy, ctl_q};
        buf_rdata = rxbuf_q;
        irq       = irq_en && (|ctl_q[B_TC:B_MODF]);
        sclk_o    = sclk_q;
        sclk_oe   = en && mstm;
        mosi_o    = tx_q[CHAR_W-1];
        mosi_oe   = en && mstm;
        miso_o    = tx_q[CHAR_W-1];
        miso_oe   = (state == ST_S_SEL) || (state == ST_S_XFER);
    end

    // checks on the control logic
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_M_XFER) |-> !sclk_q);
    p_mst_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mstm && ssel_act) |=> !ctl_q[B_MST]);
    p_wcol_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_we) |=> ctl_q[B_WCOL]);
    p_keep_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (unread_q && !buf_re) |=> $stable(rxbuf_q));
    p_tc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_TC] && !ctl_we) |=> ctl_q[B_TC]);
    p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    p_miso_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> $past(ssel_act));
endmodule

// File: tb/spi_fault_ctl_tb.sv
`timescale 1ns/1ps
module spi_fault_ctl_tb;
    localparam int HALF_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, data_we = 1'b0, buf_re = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] ctl_rdata, buf_rdata;
    logic       irq_en = 1'b1, irq;
    logic       sclk_i = 1'b0, sclk_o, sclk_oe;
    logic       mosi_i = 1'b0, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe;
    logic       ssel_n_i = 1'b1;

    int         total = 0, fails = 0;
    int         rise_cnt = 0, base = 0;
    logic [7:0] slv = '0, mosi_cap = '0;

    always #2.5 clk = ~clk;

    spi_fault_ctl #(.HALF_DIV(HALF_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .data_we(data_we),
        .buf_re(buf_re), .wdata(wdata), .ctl_rdata(ctl_rdata),
        .buf_rdata(buf_rdata), .irq_en(irq_en), .irq(irq),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ssel_n_i(ssel_n_i)
    );

    // remote slave model for master transfers
    always @(posedge sclk_o) begin
        rise_cnt <= rise_cnt + 1;
        mosi_cap <= {mosi_cap[6:0], mosi_o};
    end
    assign miso_i = slv[~3'(rise_cnt - base)];

    function automatic logic [7:0] mk_ctl(input bit busy, tc, rovr, wcol,
                                          modf, fde, mst, en);
        return {busy, tc, rovr, wcol, modf, fde, mst, en};
    endfunction

    function automatic logic exp_irq(input logic [7:0] c, input logic ie);
        return ie && (|c[6:3]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic rd_buf();
        @(negedge clk); buf_re = 1'b1;
        @(negedge clk); buf_re = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (ctl_rdata[7] && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sb, output int n);
        slv  = sb;
        base = rise_cnt;
        wr_data(tx);
        chk("R4 busy after start", ctl_rdata[7], 1'b1);
        wait_idle(n);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n;
        logic [7:0] tx, sb, mb, cap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ctl", ctl_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 oe", {sclk_oe, mosi_oe, miso_oe, sclk_o}, 4'h0);

        // R2 busy ignored; R10 software-set flags; R11 irq masking
        wr_ctl(8'hF8);
        chk("R2 busy bit read-only", ctl_rdata, mk_ctl(0,1,1,1,1,0,0,0));
        chk("R10 sw set raises irq", irq, exp_irq(ctl_rdata, irq_en));
        irq_en = 1'b0; @(negedge clk);
        chk("R11 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        wr_ctl(8'h70);
        chk("R10 write 0 clears only that flag", ctl_rdata, mk_ctl(0,1,1,1,0,0,0,0));
        wr_ctl(8'h00);
        chk("R11 irq low with no flag", irq, 1'b0);

        // R3 disabled engine ignores data write
        wr_ctl(8'h02);
        wr_data(8'h55);
        repeat (20) @(negedge clk);
        chk("R3 no transfer when disabled", ctl_rdata, mk_ctl(0,0,0,0,0,0,1,0));
        chk("R3 sclk still", sclk_o, 1'b0);

        // R3 disable mid-transfer aborts
        wr_ctl(8'h03);
        wr_data(8'h55);
        chk("R2 busy reads 1", ctl_rdata[7], 1'b1);
        repeat (10) @(negedge clk);
        wr_ctl(8'h02);
        repeat (2) @(negedge clk);
        chk("R3 abort on disable", ctl_rdata, mk_ctl(0,0,0,0,0,0,1,0));
        chk("R3 sclk low after abort", sclk_o, 1'b0);

        // R4 random master transfers
        for (int i = 0; i < 6; i++) begin
            tx = 8'($urandom);
            sb = 8'($urandom);
            wr_ctl(8'h03);
            m_xfer(tx, sb, n);
            chk("R4 busy length", n, 16 * HALF_DIV);
            chk("R4 rx byte", buf_rdata, sb);
            chk("R4 mosi byte", mosi_cap, tx);
            chk("R4 complete flag", ctl_rdata, mk_ctl(0,1,0,0,0,0,1,1));
            chk("R11 irq on complete", irq, exp_irq(ctl_rdata, irq_en));
            rd_buf();
        end

        // R8 write collision
        wr_ctl(8'h03);
        slv = 8'h3C; base = rise_cnt;
        wr_data(8'h81);
        repeat (5) @(negedge clk);
        wr_data(8'hFF);
        chk("R8 collision flag", ctl_rdata[4], 1'b1);
        wait_idle(n);
        chk("R8 mosi unchanged", mosi_cap, 8'h81);
        chk("R8 rx unchanged", buf_rdata, 8'h3C);
        rd_buf();

        // R9 overrun keeps older character
        wr_ctl(8'h03);
        m_xfer(8'h22, 8'h11, n);
        m_xfer(8'h33, 8'h99, n);
        chk("R9 overrun flag", ctl_rdata[5], 1'b1);
        chk("R9 older kept", buf_rdata, 8'h11);
        rd_buf();

        // R6 select ignored without fault detection
        wr_ctl(8'h03);
        ssel_n_i = 1'b0; repeat (6) @(negedge clk);
        chk("R6 ignored when disabled", ctl_rdata, mk_ctl(0,0,0,0,0,0,1,1));
        ssel_n_i = 1'b1; repeat (6) @(negedge clk);

        // R6/R7 fault during transfer
        wr_ctl(8'h07);
        slv = 8'h00; base = rise_cnt;
        wr_data(8'h5A);
        repeat (12) @(negedge clk);
        ssel_n_i = 1'b0; repeat (6) @(negedge clk);
        chk("R7 abort state", ctl_rdata, mk_ctl(0,0,0,0,1,1,0,1));
        chk("R7 outputs released", {sclk_oe, mosi_oe, sclk_o}, 3'b000);
        chk("R6 fault irq", irq, 1'b1);

        // R5 master bit blocked while selected
        wr_ctl(8'h03);
        chk("R5 blocked", ctl_rdata, mk_ctl(0,0,0,0,0,0,0,1));
        ssel_n_i = 1'b1; repeat (6) @(negedge clk);
        wr_ctl(8'h03);
        chk("R5 allowed when idle", ctl_rdata, mk_ctl(0,0,0,0,0,0,1,1));

        // R12 slave exchange
        wr_ctl(8'h01);
        wr_data(8'hA5);
        repeat (4) @(negedge clk);
        chk("R12 miso released unselected", miso_oe, 1'b0);
        ssel_n_i = 1'b0; repeat (6) @(negedge clk);
        chk("R12 miso driven when selected", miso_oe, 1'b1);
        mb = 8'($urandom);
        cap = '0;
        for (int b = 7; b >= 0; b--) begin
            mosi_i = mb[b];
            repeat (8) @(negedge clk);
            cap = {cap[6:0], miso_o};
            sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        chk("R12 slave rx", buf_rdata, mb);
        chk("R12 slave miso", cap, 8'hA5);
        chk("R12 slave complete", ctl_rdata, mk_ctl(0,1,0,0,0,0,0,1));
        ssel_n_i = 1'b1; repeat (6) @(negedge clk);
        chk("R12 miso released after deselect", miso_oe, 1'b0);

        finish_run();
    end
endmodule